// File: doc/BRIEF.md
# ISA Bus Cycle Generator with Four-Channel DMA

This block turns requests from two internal sources into cycles on an 8-bit ISA-style external bus. The first source is an embedded microcontroller, which issues single memory or I/O reads and writes through a held request and done handshake. The second is a four-channel DMA engine. Each DMA channel is loaded with a start address, a transfer count and a direction through a simple configuration port. It then moves one byte per request between a memory slave and an I/O slave.

Every bus cycle has three phases: an address setup phase, a command phase of fixed minimum length, and a release phase that holds the address. On DMA cycles the command phase is stretched by the READY input. On microcontroller cycles READY is never honoured. AEN separates DMA traffic from cycles that I/O slaves should decode. When the external bus-master input is asserted, the block lets go of the shared bus at once, abandons any cycle in progress, and reports that cycle as aborted once the bus comes back.

Top module: `isa_cycle_gen`

## Requirements
- R1: After reset, all four strobes are high (inactive), `dack_n` is 4'b1111, `tc` is 0, `bus_aen` is 0, `mcu_done` is 0, and the block does not drive `bus_data`.
- R2: A microcontroller cycle asserts exactly one strobe during its command phase: `mcu_io`=1 with `mcu_we`=0 gives `bus_ior_n`, `mcu_io`=1 with `mcu_we`=1 gives `bus_iow_n`, `mcu_io`=0 with `mcu_we`=0 gives `bus_memr_n`, and `mcu_io`=0 with `mcu_we`=1 gives `bus_memw_n`. During the cycle `bus_addr` equals `mcu_addr` and `bus_aen` is 0. On writes the block drives `mcu_wdata` onto `bus_data`. On reads, `bus_data` is captured into `mcu_rdata` on the clock edge that ends the command phase.
- R3: A microcontroller cycle lasts SETUP_CLKS=1 setup clock, then exactly CMD_CLKS=3 command clocks, then 1 release clock, whatever the level of `ready`. `mcu_done` is high for the single release clock.
- R4: During a DMA cycle `bus_aen` is 1 throughout and `bus_addr` is the channel's current address. The block does not drive `bus_data`. With direction bit 1 (memory to I/O), `bus_memr_n` and `bus_iow_n` are asserted. With direction bit 0 (I/O to memory), `bus_ior_n` and `bus_memw_n` are asserted.
- R5: On a DMA cycle the command phase lasts at least CMD_CLKS clocks. After that it continues until `ready` is sampled high on a rising clock edge, and the release phase follows that edge.
- R6: `dack_n` is active low and at most one bit is low at a time. The granted channel's bit is low from the setup clock through the release clock of its cycle. A channel's request may be dropped once its acknowledge is seen.
- R7: Channel 0 has the highest priority and channel 3 the lowest. When a DMA request and a microcontroller request are both pending with the bus idle, the DMA request goes first. A DMA request that arrives during a microcontroller cycle waits until that cycle has finished.
- R8: A configuration write loads a channel's address, transfer count and direction. A count of 0 leaves the channel disabled. Each completed transfer increments the channel's address by one and decrements its count. `tc` is high for the whole of the cycle that carries the final transfer. After that transfer the channel is disabled, and its requests get no acknowledge until it is reprogrammed.
- R9: While `ext_master_n` is 0, `bus_addr`, `bus_data`, the four strobes and `bus_aen` are high impedance with no clock delay, while `dack_n` and `tc` stay driven. Any cycle in progress is abandoned at the next clock edge.
- R10: After `ext_master_n` returns to 1, an abandoned cycle is reported by a one-clock pulse on `mcu_abort` or on its channel's `dma_abort` bit, and no new cycle starts before the clock after that pulse. An abandoned DMA transfer changes neither the channel's address nor its count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mcu_req | input | 1 | Microcontroller cycle request, held until done or abort |
| mcu_io | input | 1 | 1 = I/O space, 0 = memory space |
| mcu_we | input | 1 | 1 = write, 0 = read |
| mcu_addr | input | 20 | Microcontroller cycle address |
| mcu_wdata | input | 8 | Microcontroller write data |
| mcu_done | output | 1 | One-clock pulse in the release phase of a microcontroller cycle |
| mcu_abort | output | 1 | One-clock pulse reporting an abandoned microcontroller cycle |
| mcu_rdata | output | 8 | Data captured by the last microcontroller read |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 2 | Channel selected by the configuration write |
| cfg_addr | input | 20 | Start address to load |
| cfg_len | input | 16 | Number of transfers to load |
| cfg_dir | input | 1 | 1 = memory to I/O, 0 = I/O to memory |
| dma_req | input | 4 | Active-high per-channel DMA requests |
| dma_abort | output | 4 | Per-channel one-clock abort report |
| bus_addr | output | 20 | External address, tri-stated under external master |
| bus_data | inout | 8 | External data bus |
| bus_aen | output | 1 | Address enable, high on DMA cycles |
| bus_ior_n | output | 1 | I/O read strobe, active low |
| bus_iow_n | output | 1 | I/O write strobe, active low |
| bus_memr_n | output | 1 | Memory read strobe, active low |
| bus_memw_n | output | 1 | Memory write strobe, active low |
| dack_n | output | 4 | Per-channel DMA acknowledge, active low |
| tc | output | 1 | Terminal count, high during the final transfer |
| ready | input | 1 | Slave ready, extends DMA command phases while low |
| ext_master_n | input | 1 | External bus-master override, active low |

## Verification
The embedded assertions check on every clock that microcontroller command phases never outlast their fixed count, that DMA command phases hold while READY is low, that acknowledges stay one-hot and pair with exactly one memory strobe and one I/O strobe, that terminal count appears only with an acknowledge, that the external master forces the sequencer idle, and that abort reports never overlap a running cycle. Only the bench scenarios show the values on the bus: strobe choice, address and write data, read capture, the exact number of stretched clocks, channel ordering against a pending microcontroller request, counter exhaustion, the floating of the shared pins, and an aborted transfer being retried with its count intact.

// File: rtl/isa_pkg.sv
package isa_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_CMD   = 2'd2,
    ST_HOLD  = 2'd3
  } cyc_state_t;

  typedef struct packed {
    logic ior;
    logic iow;
    logic memr;
    logic memw;
  } strobe_t;

endpackage

// File: rtl/isa_dma_chan.sv
module isa_dma_chan #(
  parameter int AW = 20,
  parameter int LW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] ld_addr,
  input  logic [LW-1:0] ld_len,
  input  logic          ld_dir,
  input  logic          step,
  output logic [AW-1:0] addr_o,
  output logic          dir_o,
  output logic          en_o,
  output logic          last_o
);

  logic [AW-1:0] addr_q, addr_d;
  logic [LW-1:0] len_q, len_d;
  logic          dir_q, dir_d;
  logic          en_q, en_d;
  logic          upd;

  assign upd = load | step;

  always_comb begin
    addr_d = addr_q;
    len_d  = len_q;
    dir_d  = dir_q;
    en_d   = en_q;
    if (load) begin
      addr_d = ld_addr;
      len_d  = ld_len;
      dir_d  = ld_dir;
      en_d   = (ld_len != '0);
    end else if (step) begin
      addr_d = addr_q + 1'b1;
      len_d  = len_q - 1'b1;
      if (len_q == LW'(1)) en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      len_q  <= '0;
      dir_q  <= 1'b0;
      en_q   <= 1'b0;
    end else if (upd) begin
      addr_q <= addr_d;
      len_q  <= len_d;
      dir_q  <= dir_d;
      en_q   <= en_d;
    end
  end

  assign addr_o = addr_q;
  assign dir_o  = dir_q;
  assign en_o   = en_q;
  assign last_o = en_q && (len_q == LW'(1));

  // R8: a transfer is only ever completed on a live channel
  a_r8_step_on_enabled: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> en_q);

endmodule

// File: rtl/isa_dma_arb.sv
module isa_dma_arb #(
  parameter int NCH = 4,
  parameter int IW  = 2
) (
  input  logic [NCH-1:0] req,
  input  logic [NCH-1:0] en,
  output logic           gvalid,
  output logic [IW-1:0]  gidx
);

  always_comb begin
    gvalid = 1'b0;
    gidx   = '0;
    for (int i = NCH - 1; i >= 0; i--) begin
      if (req[i] && en[i]) begin
        gvalid = 1'b1;
        gidx   = IW'(i);
      end
    end
  end

  // R7 / R8: any grant goes to a channel that is both requesting and enabled
  always_comb begin
    if (gvalid) begin
      a_r7_grant_is_live: assert (req[gidx] && en[gidx]);
    end
  end

endmodule

// File: rtl/isa_cycle_fsm.sv
module isa_cycle_fsm
  import isa_pkg::*;
#(
  parameter int SETUP_CLKS = 1,
  parameter int CMD_CLKS   = 3,
  localparam int MAXC      = (SETUP_CLKS > CMD_CLKS) ? SETUP_CLKS : CMD_CLKS,
  localparam int CW        = $clog2(MAXC + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       stretch_ok,
  input  logic       ready,
  input  logic       ext_master_n,
  output cyc_state_t state_o,
  output logic       leave_cmd_o
);

  cyc_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          leave_cmd;

  always_comb begin
    st_d      = st_q;
    cnt_d     = cnt_q;
    leave_cmd = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_d  = ST_SETUP;
          cnt_d = CW'(SETUP_CLKS - 1);
        end
      end
      ST_SETUP: begin
        if (cnt_q == '0) begin
          st_d  = ST_CMD;
          cnt_d = CW'(CMD_CLKS - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CMD: begin
        if (cnt_q != '0) begin
          cnt_d = cnt_q - 1'b1;
        end else if (!stretch_ok || ready) begin
          st_d      = ST_HOLD;
          leave_cmd = 1'b1;
        end
      end
      ST_HOLD: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (!ext_master_n) begin
      st_d      = ST_IDLE;
      leave_cmd = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign state_o     = st_q;
  assign leave_cmd_o = leave_cmd;

  // R3: a microcontroller command phase ends when its count runs out
  a_r3_mcu_never_stretched: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD && cnt_q == '0 && !stretch_ok && ext_master_n) |=> (st_q == ST_HOLD));

  // R5: a DMA command phase holds while ready is low
  a_r5_dma_holds_on_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CMD && cnt_q == '0 && stretch_ok && !ready && ext_master_n) |=> (st_q == ST_CMD));

  // R9: the external master abandons whatever cycle is running
  a_r9_master_forces_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_master_n |=> (st_q == ST_IDLE));

endmodule

// File: rtl/isa_cycle_gen.sv
module isa_cycle_gen
  import isa_pkg::*;
#(
  parameter int AW         = 20,
  parameter int DW         = 8,
  parameter int NCH        = 4,
  parameter int LW         = 16,
  parameter int SETUP_CLKS = 1,
  parameter int CMD_CLKS   = 3,
  localparam int CHW       = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           mcu_req,
  input  logic           mcu_io,
  input  logic           mcu_we,
  input  logic [AW-1:0]  mcu_addr,
  input  logic [DW-1:0]  mcu_wdata,
  output logic           mcu_done,
  output logic           mcu_abort,
  output logic [DW-1:0]  mcu_rdata,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [AW-1:0]  cfg_addr,
  input  logic [LW-1:0]  cfg_len,
  input  logic           cfg_dir,
  input  logic [NCH-1:0] dma_req,
  output logic [NCH-1:0] dma_abort,
  output wire  [AW-1:0]  bus_addr,
  inout  wire  [DW-1:0]  bus_data,
  output wire            bus_aen,
  output wire            bus_ior_n,
  output wire            bus_iow_n,
  output wire            bus_memr_n,
  output wire            bus_memw_n,
  output logic [NCH-1:0] dack_n,
  output logic           tc,
  input  logic           ready,
  input  logic           ext_master_n
);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  // DMA channels
  logic [NCH-1:0]         ch_en, ch_last, ch_dir, ch_load, ch_step;
  logic [NCH-1:0][AW-1:0] ch_addr;
  logic                   gvalid;
  logic [CHW-1:0]         gidx;
  logic                   done;

  // cycle context
  logic           ctx_dma_q, ctx_io_q, ctx_we_q, ctx_dir_q;
  logic [CHW-1:0] ctx_ch_q;
  logic [AW-1:0]  ctx_addr_q;
  logic [DW-1:0]  ctx_wdata_q;

  genvar g;
  generate
    for (g = 0; g < NCH; g++) begin : g_chan
      assign ch_load[g] = cfg_we && (cfg_ch == CHW'(g));
      assign ch_step[g] = done && ctx_dma_q && (ctx_ch_q == CHW'(g));
      isa_dma_chan #(.AW(AW), .LW(LW)) u_chan (
        .clk     (clk),
        .rst_n   (rst_s),
        .load    (ch_load[g]),
        .ld_addr (cfg_addr),
        .ld_len  (cfg_len),
        .ld_dir  (cfg_dir),
        .step    (ch_step[g]),
        .addr_o  (ch_addr[g]),
        .dir_o   (ch_dir[g]),
        .en_o    (ch_en[g]),
        .last_o  (ch_last[g])
      );
    end
  endgenerate

  isa_dma_arb #(.NCH(NCH), .IW(CHW)) u_arb (
    .req    (dma_req),
    .en     (ch_en),
    .gvalid (gvalid),
    .gidx   (gidx)
  );

  // sequencer
  cyc_state_t st;
  logic       leave_cmd, start, busy, abort_pend_q;

  assign start = (st == ST_IDLE) && ext_master_n && !abort_pend_q && (gvalid || mcu_req);

  isa_cycle_fsm #(.SETUP_CLKS(SETUP_CLKS), .CMD_CLKS(CMD_CLKS)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_s),
    .start        (start),
    .stretch_ok   (ctx_dma_q),
    .ready        (ready),
    .ext_master_n (ext_master_n),
    .state_o      (st),
    .leave_cmd_o  (leave_cmd)
  );

  assign busy = (st != ST_IDLE);
  assign done = (st == ST_HOLD) && ext_master_n;

  // context capture at cycle start
  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      ctx_dma_q   <= 1'b0;
      ctx_io_q    <= 1'b0;
      ctx_we_q    <= 1'b0;
      ctx_dir_q   <= 1'b0;
      ctx_ch_q    <= '0;
      ctx_addr_q  <= '0;
      ctx_wdata_q <= '0;
    end else if (start) begin
      ctx_dma_q   <= gvalid;
      ctx_io_q    <= mcu_io;
      ctx_we_q    <= mcu_we;
      ctx_dir_q   <= ch_dir[gidx];
      ctx_ch_q    <= gidx;
      ctx_addr_q  <= gvalid ? ch_addr[gidx] : mcu_addr;
      ctx_wdata_q <= mcu_wdata;
    end
  end

  // strobe decode
  strobe_t str;
  logic    cmd_act;

  assign cmd_act = (st == ST_CMD);

  always_comb begin
    str = '0;
    if (cmd_act) begin
      if (ctx_dma_q) begin
        str.memr = ctx_dir_q;
        str.iow  = ctx_dir_q;
        str.ior  = !ctx_dir_q;
        str.memw = !ctx_dir_q;
      end else begin
        str.ior  = ctx_io_q  && !ctx_we_q;
        str.iow  = ctx_io_q  &&  ctx_we_q;
        str.memr = !ctx_io_q && !ctx_we_q;
        str.memw = !ctx_io_q &&  ctx_we_q;
      end
    end
  end

  // acknowledges and terminal count stay driven under external master
  logic [NCH-1:0] dack_act;
  generate
    for (g = 0; g < NCH; g++) begin : g_dack
      assign dack_act[g] = busy && ctx_dma_q && (ctx_ch_q == CHW'(g));
    end
  endgenerate
  assign dack_n = ~dack_act;
  assign tc     = busy && ctx_dma_q && ch_last[ctx_ch_q];

  // shared bus pins with release under external master
  logic drive_data;
  assign drive_data = busy && !ctx_dma_q && ctx_we_q && ext_master_n;

  assign bus_addr   = ext_master_n ? ctx_addr_q : {AW{1'bz}};
  assign bus_aen    = ext_master_n ? (busy && ctx_dma_q) : 1'bz;
  assign bus_ior_n  = ext_master_n ? !str.ior  : 1'bz;
  assign bus_iow_n  = ext_master_n ? !str.iow  : 1'bz;
  assign bus_memr_n = ext_master_n ? !str.memr : 1'bz;
  assign bus_memw_n = ext_master_n ? !str.memw : 1'bz;
  assign bus_data   = drive_data ? ctx_wdata_q : {DW{1'bz}};

  // read capture
  logic          cap_en;
  logic [DW-1:0] rdata_q;

  assign cap_en = leave_cmd && !ctx_dma_q && !ctx_we_q;

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)      rdata_q <= '0;
    else if (cap_en) rdata_q <= bus_data;
  end

  assign mcu_rdata = rdata_q;
  assign mcu_done  = done && !ctx_dma_q;

  // abort bookkeeping
  logic           abort_pend_d, ab_dma_q, ab_dma_d, mab_q, mab_d;
  logic [CHW-1:0] ab_ch_q, ab_ch_d;
  logic [NCH-1:0] dab_q, dab_d;

  always_comb begin
    abort_pend_d = abort_pend_q;
    ab_dma_d     = ab_dma_q;
    ab_ch_d      = ab_ch_q;
    mab_d        = 1'b0;
    dab_d        = '0;
    if (!ext_master_n && busy) begin
      abort_pend_d = 1'b1;
      ab_dma_d     = ctx_dma_q;
      ab_ch_d      = ctx_ch_q;
    end else if (ext_master_n && abort_pend_q) begin
      abort_pend_d = 1'b0;
      if (ab_dma_q) dab_d[ab_ch_q] = 1'b1;
      else          mab_d          = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      abort_pend_q <= 1'b0;
      ab_dma_q     <= 1'b0;
      ab_ch_q      <= '0;
      mab_q        <= 1'b0;
      dab_q        <= '0;
    end else begin
      abort_pend_q <= abort_pend_d;
      ab_dma_q     <= ab_dma_d;
      ab_ch_q      <= ab_ch_d;
      mab_q        <= mab_d;
      dab_q        <= dab_d;
    end
  end

  assign mcu_abort = mab_q;
  assign dma_abort = dab_q;

  // R6: never more than one acknowledge at a time
  a_r6_dack_onehot: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0(~dack_n));

  // R4: an acknowledged command phase pairs one memory and one I/O strobe
  a_r4_dma_strobe_pair: assert property (@(posedge clk) disable iff (!rst_s)
    (cmd_act && !(&dack_n)) |-> ($countones(str) == 2 && (str.ior || str.iow) && (str.memr || str.memw)));

  // R8: terminal count only accompanies an acknowledged cycle
  a_r8_tc_with_dack: assert property (@(posedge clk) disable iff (!rst_s)
    tc |-> !(&dack_n));

  // R10: an abort report never overlaps a running cycle
  a_r10_report_while_idle: assert property (@(posedge clk) disable iff (!rst_s)
    (mcu_abort || (|dma_abort)) |-> (st == ST_IDLE));

endmodule

// File: tb/tb_isa_cycle_gen.sv
module tb_isa_cycle_gen;

  logic        clk, rst_n;
  logic        mcu_req, mcu_io, mcu_we;
  logic [19:0] mcu_addr;
  logic [7:0]  mcu_wdata;
  logic        mcu_done, mcu_abort;
  logic [7:0]  mcu_rdata;
  logic        cfg_we, cfg_dir;
  logic [1:0]  cfg_ch;
  logic [19:0] cfg_addr;
  logic [15:0] cfg_len;
  logic [3:0]  dma_req, dma_abort, dack_n;
  logic        tc, ready, ext_master_n;

  // pulled-down bus nets: a released pin reads 0
  tri0 [19:0] bus_addr;
  tri0 [7:0]  bus_data;
  tri0        bus_aen, bus_ior_n, bus_iow_n, bus_memr_n, bus_memw_n;

  wire [3:0] strobes = {~bus_ior_n, ~bus_iow_n, ~bus_memr_n, ~bus_memw_n};

  // slave model: reads return address low byte xor 5A
  wire slv_oe = ext_master_n && (!bus_ior_n || !bus_memr_n);
  assign bus_data = slv_oe ? (bus_addr[7:0] ^ 8'h5A) : 8'bz;

  isa_cycle_gen dut (
    .clk(clk), .rst_n(rst_n),
    .mcu_req(mcu_req), .mcu_io(mcu_io), .mcu_we(mcu_we),
    .mcu_addr(mcu_addr), .mcu_wdata(mcu_wdata),
    .mcu_done(mcu_done), .mcu_abort(mcu_abort), .mcu_rdata(mcu_rdata),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_addr(cfg_addr), .cfg_len(cfg_len), .cfg_dir(cfg_dir),
    .dma_req(dma_req), .dma_abort(dma_abort),
    .bus_addr(bus_addr), .bus_data(bus_data), .bus_aen(bus_aen),
    .bus_ior_n(bus_ior_n), .bus_iow_n(bus_iow_n), .bus_memr_n(bus_memr_n), .bus_memw_n(bus_memw_n),
    .dack_n(dack_n), .tc(tc), .ready(ready), .ext_master_n(ext_master_n)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog run did not finish actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  // io, we, ready, addr, wdata
  localparam logic [30:0] MCU_VEC [0:5] = '{
    {1'b1, 1'b0, 1'b1, 20'h003F8, 8'h00},
    {1'b1, 1'b1, 1'b0, 20'h00060, 8'hA5},
    {1'b0, 1'b0, 1'b0, 20'hC8000, 8'h00},
    {1'b0, 1'b1, 1'b1, 20'hFFFFF, 8'h3C},
    {1'b1, 1'b1, 1'b0, 20'h00000, 8'hFF},
    {1'b0, 1'b0, 1'b1, 20'h7A5C3, 8'h00}
  };

  task automatic program_ch(input int ch, input logic [19:0] a, input logic [15:0] n, input bit dir);
    @(negedge clk);
    cfg_we = 1'b1; cfg_ch = 2'(ch); cfg_addr = a; cfg_len = n; cfg_dir = dir;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic mcu_run(input bit io, input bit we, input bit rdy, input logic [19:0] a, input logic [7:0] wd,
                         output int cmd_n, output int total, output logic [3:0] s_seen,
                         output logic [19:0] a_seen, output logic [7:0] d_seen, output bit aen_bad);
    cmd_n = 0; total = 0; s_seen = '0; a_seen = '0; d_seen = '0; aen_bad = 1'b0;
    @(negedge clk);
    mcu_io = io; mcu_we = we; mcu_addr = a; mcu_wdata = wd; ready = rdy; mcu_req = 1'b1;
    do begin
      @(negedge clk);
      total++;
      if (strobes != 4'b0) begin
        cmd_n++; s_seen = strobes; a_seen = bus_addr; d_seen = bus_data;
      end
      if (bus_aen !== 1'b0) aen_bad = 1'b1;
    end while (!mcu_done && total < 40);
    mcu_req = 1'b0;
    ready = 1'b1;
  endtask

  task automatic dma_xfer(input int ch, input int extra, output int cmd_n, output logic [19:0] a_seen,
                          output logic [3:0] s_seen, output bit tc_seen, output bit aen_bad);
    int guard;
    cmd_n = 0; a_seen = '0; s_seen = '0; tc_seen = 1'b0; aen_bad = 1'b0;
    @(negedge clk);
    ready = (extra == 0);
    dma_req[ch] = 1'b1;
    guard = 0;
    while (dack_n[ch] !== 1'b0 && guard < 30) begin @(negedge clk); guard++; end
    dma_req[ch] = 1'b0;
    guard = 0;
    while (dack_n[ch] === 1'b0 && guard < 60) begin
      if (strobes != 4'b0) begin cmd_n++; a_seen = bus_addr; s_seen = strobes; end
      if (tc) tc_seen = 1'b1;
      if (bus_aen !== 1'b1) aen_bad = 1'b1;
      if (cmd_n == 3 + extra) ready = 1'b1;
      @(negedge clk);
      guard++;
    end
    ready = 1'b1;
  endtask

  initial begin
    int cmd_n, total, guard, cnt;
    logic [3:0] s_seen;
    logic [19:0] a_seen;
    logic [7:0] d_seen;
    bit aen_bad, tc_seen, bad;
    int order [3];
    int nord;

    rst_n = 1'b0; mcu_req = 1'b0; mcu_io = 1'b0; mcu_we = 1'b0; mcu_addr = '0; mcu_wdata = '0;
    cfg_we = 1'b0; cfg_ch = '0; cfg_addr = '0; cfg_len = '0; cfg_dir = 1'b0;
    dma_req = '0; ready = 1'b1; ext_master_n = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "strobes idle", {bus_ior_n, bus_iow_n, bus_memr_n, bus_memw_n}, 4'hF);
    chk("R1", "dack_n", dack_n, 4'hF);
    chk("R1", "tc/aen/done", {tc, bus_aen, mcu_done}, 3'b000);
    chk("R1", "data undriven", bus_data, 8'h00);

    // table of microcontroller cycles: R2 and R3
    foreach (MCU_VEC[i]) begin
      logic [3:0] exp_s;
      logic io, we, rdy;
      logic [19:0] a;
      logic [7:0] wd;
      {io, we, rdy, a, wd} = MCU_VEC[i];
      exp_s = io ? (we ? 4'b0100 : 4'b1000) : (we ? 4'b0001 : 4'b0010);
      mcu_run(io, we, rdy, a, wd, cmd_n, total, s_seen, a_seen, d_seen, aen_bad);
      chk("R3", $sformatf("vec%0d command clocks", i), cmd_n, 3);
      chk("R3", $sformatf("vec%0d total clocks", i), total, 5);
      chk("R2", $sformatf("vec%0d strobe", i), s_seen, exp_s);
      chk("R2", $sformatf("vec%0d address", i), a_seen, a);
      chk("R2", $sformatf("vec%0d aen low", i), aen_bad, 0);
      if (we) chk("R2", $sformatf("vec%0d write data", i), d_seen, wd);
      else    chk("R2", $sformatf("vec%0d read capture", i), mcu_rdata, a[7:0] ^ 8'h5A);
    end

    // DMA: channel 2, memory to I/O, two transfers
    program_ch(2, 20'h12340, 16'd2, 1'b1);
    dma_xfer(2, 0, cmd_n, a_seen, s_seen, tc_seen, aen_bad);
    chk("R4", "dma strobe pair mem->io", s_seen, 4'b0110);
    chk("R4", "dma address first", a_seen, 20'h12340);
    chk("R4", "aen high in dma", aen_bad, 0);
    chk("R5", "dma command with ready high", cmd_n, 3);
    chk("R8", "no tc on first transfer", tc_seen, 0);
    dma_xfer(2, 3, cmd_n, a_seen, s_seen, tc_seen, aen_bad);
    chk("R5", "dma command stretched", cmd_n, 6);
    chk("R8", "address advanced", a_seen, 20'h12341);
    chk("R8", "tc on final transfer", tc_seen, 1);

    // R8: exhausted channel ignored
    @(negedge clk);
    dma_req[2] = 1'b1;
    bad = 1'b0;
    repeat (10) begin @(negedge clk); if (dack_n !== 4'hF || strobes != 4'b0) bad = 1'b1; end
    dma_req[2] = 1'b0;
    chk("R8", "disabled channel ignored", bad, 0);

    // R4 other direction, R7 priority and DMA before MCU
    program_ch(1, 20'h00100, 16'd1, 1'b1);
    program_ch(3, 20'h00300, 16'd1, 1'b0);
    @(negedge clk);
    mcu_io = 1'b0; mcu_we = 1'b1; mcu_addr = 20'h00555; mcu_wdata = 8'h11;
    dma_req[1] = 1'b1; dma_req[3] = 1'b1; mcu_req = 1'b1;
    nord = 0; bad = 1'b0; s_seen = '0;
    for (int k = 0; k < 60 && nord < 3; k++) begin
      @(negedge clk);
      if (!$onehot0(~dack_n)) bad = 1'b1;
      if (dack_n[1] === 1'b0 && dma_req[1]) begin dma_req[1] = 1'b0; order[nord] = 1; nord++; end
      if (dack_n[3] === 1'b0 && dma_req[3]) begin dma_req[3] = 1'b0; order[nord] = 3; nord++; end
      if (dack_n[3] === 1'b0 && strobes != 4'b0) s_seen = strobes;
      if (mcu_done && mcu_req) begin mcu_req = 1'b0; order[nord] = 9; nord++; end
    end
    chk("R7", "first grant channel 1", order[0], 1);
    chk("R7", "second grant channel 3", order[1], 3);
    chk("R7", "mcu served last", order[2], 9);
    chk("R6", "acknowledges one-hot", bad, 0);
    chk("R4", "dma strobe pair io->mem", s_seen, 4'b1001);

    // R7: DMA waits for a running MCU cycle
    program_ch(0, 20'h00A00, 16'd1, 1'b0);
    @(negedge clk);
    mcu_io = 1'b1; mcu_we = 1'b0; mcu_addr = 20'h00278; mcu_req = 1'b1;
    @(negedge clk);
    dma_req[0] = 1'b1;
    bad = 1'b0; guard = 0;
    while (!mcu_done && guard < 20) begin
      if (dack_n !== 4'hF) bad = 1'b1;
      @(negedge clk); guard++;
    end
    mcu_req = 1'b0;
    chk("R7", "no grant during mcu cycle", bad, 0);
    guard = 0;
    while (dack_n[0] !== 1'b0 && guard < 6) begin @(negedge clk); guard++; end
    dma_req[0] = 1'b0;
    chk("R6", "channel 0 acknowledged after mcu", dack_n, 4'b1110);
    guard = 0;
    while (dack_n !== 4'hF && guard < 20) begin @(negedge clk); guard++; end

    // R9 / R10: DMA cycle abandoned by external master
    program_ch(0, 20'h40000, 16'd2, 1'b0);
    @(negedge clk);
    dma_req[0] = 1'b1;
    guard = 0;
    while (dack_n[0] !== 1'b0 && guard < 10) begin @(negedge clk); guard++; end
    dma_req[0] = 1'b0;
    guard = 0;
    while (strobes == 4'b0 && guard < 10) begin @(negedge clk); guard++; end
    ext_master_n = 1'b0;
    #1;
    chk("R9", "aen released", bus_aen, 0);
    chk("R9", "address released", bus_addr, 20'h0);
    chk("R9", "strobes released", {bus_ior_n, bus_iow_n, bus_memr_n, bus_memw_n}, 4'h0);
    chk("R9", "dack still driven", dack_n, 4'b1110);
    @(negedge clk);
    chk("R9", "cycle abandoned", dack_n, 4'hF);
    repeat (3) @(negedge clk);
    chk("R10", "no report while master holds bus", dma_abort, 4'h0);
    ext_master_n = 1'b1;
    cnt = 0; bad = 1'b0;
    repeat (4) begin
      @(negedge clk);
      if (dma_abort === 4'b0001) cnt++;
      else if (dma_abort !== 4'b0000) bad = 1'b1;
    end
    chk("R10", "single abort pulse channel 0", cnt, 1);
    chk("R10", "no stray abort bits", bad, 0);
    dma_xfer(0, 0, cmd_n, a_seen, s_seen, tc_seen, aen_bad);
    chk("R10", "retry keeps address", a_seen, 20'h40000);
    chk("R10", "retry keeps count", tc_seen, 0);
    dma_xfer(0, 0, cmd_n, a_seen, s_seen, tc_seen, aen_bad);
    chk("R8", "final after retry has tc", tc_seen, 1);

    // R10: MCU cycle abandoned
    @(negedge clk);
    mcu_io = 1'b1; mcu_we = 1'b1; mcu_addr = 20'h00300; mcu_wdata = 8'h77; mcu_req = 1'b1;
    guard = 0;
    while (strobes == 4'b0 && guard < 10) begin @(negedge clk); guard++; end
    ext_master_n = 1'b0;
    #1;
    chk("R9", "write data released", bus_data, 8'h00);
    repeat (2) @(negedge clk);
    ext_master_n = 1'b1;
    cnt = 0; bad = 1'b0;
    repeat (6) begin
      @(negedge clk);
      if (mcu_abort) begin cnt++; mcu_req = 1'b0; end
      if (mcu_done || strobes != 4'b0) bad = 1'b1;
    end
    chk("R10", "mcu abort pulse", cnt, 1);
    chk("R10", "no cycle restarted", bad, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule